// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block owns the processor status word of a 32-bit core (operating mode, instruction-state bit, and the two interrupt mask bits) together with one saved copy of that word for each privileged mode that can be the target of an exception. Each clock it looks at the pending exception causes, picks the most urgent one that is not masked, and carries out the whole entry in a single edge. The entry does the following:

- asks the banked register file to store the return address in the target mode's link register;
- saves the current status into that mode's saved-status slot;
- switches mode and sets the mask bits;
- redirects the program counter to the cause's vector.

The decode logic can also issue a return command. On a return, the block restores the status from the current mode's saved slot. It also loads the program counter with the link value supplied by the register file, minus a cause-dependent adjustment. A privileged status write port lets software change the mode and the mask and state bits directly.

All outputs are registered. A program-counter load is signalled by a one-cycle `pc_load` pulse.

Top module: `exc_seq`

## Requirements
- R1: While `rst` is high, the next clock edge leaves mode 5'h13 (supervisor), T=0, I=1, F=1, `pc_out`=`VEC_BASE` (offset 0) and `pc_load`=1, with `lr_we`=0.
- R2: On an entry, `lr_we` is high for one cycle. In that cycle `lr_mode` holds the target mode and `lr_data` holds the `next_pc` value sampled at the edge where the entry was taken.
- R3: On an entry, the status word held just before the entry is stored as the target mode's saved status. A later return from that mode restores it.
- R4: On an entry, the mode becomes the target mode, T clears and I sets. F sets on a fast-interrupt entry and otherwise keeps its value.
- R5: On an entry, `pc_load`=1 and `pc_out`=`VEC_BASE` plus an offset. The offsets are: 0x04 undefined (mode 5'h1B), 0x08 software call (mode 5'h13), 0x0C prefetch abort (mode 5'h17), 0x10 data abort (mode 5'h17), 0x18 interrupt (mode 5'h12), 0x1C fast interrupt (mode 5'h11).
- R6: When several causes are pending together, exactly one is taken. The order from most to least urgent is: data abort, fast interrupt, interrupt, prefetch abort, undefined, software call.
- R7: `irq` is ignored while I=1, and `fiq` is ignored while F=1.
- R8: A return (`ret_req`) in a mode with a saved slot restores mode, T, I and F from that slot and loads `pc_out` with `lr_in` minus 8. The minus 8 applies when the slot was last written by a data-abort entry; in every other case the adjustment is minus 4. `pc_load`=1 in that cycle.
- R9: A return requested in user mode (5'h10) or system mode (5'h1F) has no effect: the status is unchanged and `pc_load`=0.
- R10: A status write (`ctl_wr`) takes its fields from `ctl_wdata`: mode in [7:3], T in [2], I in [1], F in [0]. It replaces the status only when the current mode is not user mode and the written mode is one of 5'h10, 11, 12, 13, 17, 1B, 1F. Otherwise it is ignored.
- R11: In one cycle, a taken exception overrides both a return and a status write, and a return overrides a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; performs the reset entry |
| req_undef | input | 1 | Undefined-instruction cause |
| req_swi | input | 1 | Software-call cause |
| req_pabt | input | 1 | Prefetch-abort cause |
| req_dabt | input | 1 | Data-abort cause |
| irq | input | 1 | Interrupt request (level) |
| fiq | input | 1 | Fast interrupt request (level) |
| next_pc | input | ADDR_W | Address of the next instruction of the running code |
| ret_req | input | 1 | Exception-return command |
| lr_in | input | ADDR_W | Current mode's link register value from the register file |
| ctl_wr | input | 1 | Status write strobe |
| ctl_wdata | input | 8 | Status write data {mode, T, I, F} |
| pc_load | output | 1 | One-cycle pulse: load `pc_out` into the program counter |
| pc_out | output | ADDR_W | New program counter value |
| mode | output | 5 | Current mode |
| t_bit | output | 1 | 1 = 16-bit instruction state |
| i_bit | output | 1 | Interrupt mask |
| f_bit | output | 1 | Fast interrupt mask |
| lr_we | output | 1 | Link register write request |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | ADDR_W | Value for that link register |

## Verification
The collisions of interest are an exception entry arriving in the same cycle as a return command or a status write, and a return arriving together with a status write. The bench raises a software call together with `ret_req` and with `ctl_wr`, and also a return together with a write. A behavioural model decides the winner from the stated precedence. The model then checks status, program counter and link-request outputs on every clock. Subsequent returns show whether the losing command left any trace in the saved slots.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [4:0] {
    M_USR = 5'h10,
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_UND = 5'h1B,
    M_SYS = 5'h1F
  } mode_e;

  typedef struct packed {
    logic [4:0] mode;
    logic       t;
    logic       i;
    logic       f;
  } status_t;

  localparam int STATUS_W  = $bits(status_t);
  // causes by urgency, index 0 most urgent
  localparam int NUM_EXC   = 6;
  localparam int EXC_IW    = $clog2(NUM_EXC);
  localparam int X_DABT    = 0;
  localparam int X_FIQ     = 1;
  localparam int X_IRQ     = 2;
  localparam int X_PABT    = 3;
  localparam int X_UNDEF   = 4;
  localparam int X_SWI     = 5;
  localparam int NUM_BANKS = 5;
  localparam int BANK_AW   = $clog2(NUM_BANKS);

  function automatic logic [4:0] exc_target(input logic [EXC_IW-1:0] k);
    case (k)
      EXC_IW'(X_DABT):  return M_ABT;
      EXC_IW'(X_FIQ):   return M_FIQ;
      EXC_IW'(X_IRQ):   return M_IRQ;
      EXC_IW'(X_PABT):  return M_ABT;
      EXC_IW'(X_UNDEF): return M_UND;
      default:          return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] exc_offset(input logic [EXC_IW-1:0] k);
    case (k)
      EXC_IW'(X_DABT):  return 8'h10;
      EXC_IW'(X_FIQ):   return 8'h1C;
      EXC_IW'(X_IRQ):   return 8'h18;
      EXC_IW'(X_PABT):  return 8'h0C;
      EXC_IW'(X_UNDEF): return 8'h04;
      default:          return 8'h08;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic has_bank(input logic [4:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_AW-1:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return BANK_AW'(0);
      M_IRQ:   return BANK_AW'(1);
      M_SVC:   return BANK_AW'(2);
      M_ABT:   return BANK_AW'(3);
      default: return BANK_AW'(4);
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NUM     = NUM_EXC,
  parameter int IRQ_POS = X_IRQ,
  parameter int FIQ_POS = X_FIQ,
  localparam int IW     = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NUM-1:0] req,
  input  logic          i_mask,
  input  logic          f_mask,
  output logic          take,
  output logic [IW-1:0] idx
);

  logic [NUM-1:0] eff;

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_mask
      if (g == IRQ_POS) begin : g_irq
        assign eff[g] = req[g] & ~i_mask;
      end else if (g == FIQ_POS) begin : g_fiq
        assign eff[g] = req[g] & ~f_mask;
      end else begin : g_plain
        assign eff[g] = req[g];
      end
    end
  endgenerate

  // scan from least urgent so the most urgent pending cause wins
  always_comb begin
    take = 1'b0;
    idx  = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (eff[k]) begin
        take = 1'b1;
        idx  = IW'(k);
      end
    end
  end

  // R7: a masked interrupt cause is never granted
  a_r7_mask_respected: assert property (@(posedge clk) disable iff (rst)
    take |-> !((idx == IW'(IRQ_POS)) && i_mask) && !((idx == IW'(FIQ_POS)) && f_mask));

  // R6: no pending cause more urgent than the granted one
  a_r6_no_better_pending: assert property (@(posedge clk) disable iff (rst)
    take |-> ((eff & ((NUM'(1) << idx) - NUM'(1))) == '0));

endmodule

// File: rtl/exc_status_bank.sv
module exc_status_bank #(
  parameter int W     = 9,
  parameter int DEPTH = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              irq,
  input  logic              fiq,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] lr_in,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_out,
  output logic [4:0]        mode,
  output logic              t_bit,
  output logic              i_bit,
  output logic              f_bit,
  output logic              lr_we,
  output logic [4:0]        lr_mode,
  output logic [ADDR_W-1:0] lr_data
);

  localparam int SLOT_W = STATUS_W + 1;  // status plus "deep return" flag

  status_t cpsr;
  status_t wr_st;
  logic [NUM_EXC-1:0] req_vec;
  logic               take;
  logic [EXC_IW-1:0]  idx;
  logic [4:0]         tgt;
  logic [SLOT_W-1:0]  slot_rd;
  status_t            saved_st;
  logic               saved_adj;
  logic               do_ret;
  logic               do_wr;

  assign req_vec[X_DABT]  = req_dabt;
  assign req_vec[X_FIQ]   = fiq;
  assign req_vec[X_IRQ]   = irq;
  assign req_vec[X_PABT]  = req_pabt;
  assign req_vec[X_UNDEF] = req_undef;
  assign req_vec[X_SWI]   = req_swi;

  exc_arbiter #(
    .NUM(NUM_EXC), .IRQ_POS(X_IRQ), .FIQ_POS(X_FIQ)
  ) u_arb (
    .clk(clk), .rst(rst), .req(req_vec),
    .i_mask(cpsr.i), .f_mask(cpsr.f),
    .take(take), .idx(idx)
  );

  assign tgt = exc_target(idx);

  exc_status_bank #(
    .W(SLOT_W), .DEPTH(NUM_BANKS)
  ) u_bank (
    .clk(clk),
    .we(take && !rst),
    .waddr(bank_of(tgt)),
    .wdata({cpsr, (idx == EXC_IW'(X_DABT))}),
    .raddr(bank_of(cpsr.mode)),
    .rdata(slot_rd)
  );

  assign saved_st  = status_t'(slot_rd[SLOT_W-1:1]);
  assign saved_adj = slot_rd[0];
  assign wr_st     = status_t'(ctl_wdata);
  assign do_ret    = ret_req && has_bank(cpsr.mode);
  assign do_wr     = ctl_wr && (cpsr.mode != M_USR) && mode_legal(wr_st.mode);

  always_ff @(posedge clk) begin
    pc_load <= 1'b0;
    lr_we   <= 1'b0;
    if (rst) begin
      cpsr    <= '{mode: M_SVC, t: 1'b0, i: 1'b1, f: 1'b1};
      pc_out  <= VEC_BASE;
      pc_load <= 1'b1;
      lr_mode <= M_SVC;
      lr_data <= '0;
    end else if (take) begin
      cpsr.mode <= tgt;
      cpsr.t    <= 1'b0;
      cpsr.i    <= 1'b1;
      cpsr.f    <= cpsr.f | (idx == EXC_IW'(X_FIQ));
      pc_out    <= VEC_BASE + ADDR_W'(exc_offset(idx));
      pc_load   <= 1'b1;
      lr_we     <= 1'b1;
      lr_mode   <= tgt;
      lr_data   <= next_pc;
    end else if (do_ret) begin
      cpsr    <= saved_st;
      pc_out  <= lr_in - (saved_adj ? ADDR_W'(8) : ADDR_W'(4));
      pc_load <= 1'b1;
    end else if (do_wr) begin
      cpsr <= wr_st;
    end
  end

  assign mode  = cpsr.mode;
  assign t_bit = cpsr.t;
  assign i_bit = cpsr.i;
  assign f_bit = cpsr.f;

  // R1: reset leaves supervisor mode, masked, 32-bit state, reset vector
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (mode == M_SVC) && i_bit && f_bit && !t_bit && pc_load
                   && (pc_out == VEC_BASE) && !lr_we);

  // R2: link request carries the address presented at the entry edge
  a_r2_lr_capture: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> (lr_data == $past(next_pc)) && pc_load);

  // R4: entry lands in the requested mode with masks raised, T cleared
  a_r4_entry_state: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> (mode == lr_mode) && i_bit && !t_bit);

  // R4: fast interrupt entry always ends with F set
  a_r4_fiq_sets_f: assert property (@(posedge clk) disable iff (rst)
    (lr_we && (lr_mode == M_FIQ)) |-> f_bit);

  // R5: vectors stay word aligned within the table
  a_r5_vector_range: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> ((pc_out - VEC_BASE) <= ADDR_W'(8'h1C)) && (pc_out[1:0] == 2'b00));

  // R9: a load without entry only follows from a mode that has a slot
  a_r9_ret_needs_slot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pc_load && !lr_we) |-> has_bank($past(mode)));

  // R10: outside an entry, user mode never leaves by itself
  a_r10_user_locked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == M_USR) && !lr_we) |-> (mode == M_USR));

endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_undef = 0, req_swi = 0, req_pabt = 0, req_dabt = 0;
  logic          irq = 0, fiq = 0, ret_req = 0, ctl_wr = 0;
  logic [AW-1:0] next_pc = '0, lr_in = '0;
  logic [7:0]    ctl_wdata = '0;
  logic          pc_load, t_bit, i_bit, f_bit, lr_we;
  logic [AW-1:0] pc_out, lr_data;
  logic [4:0]    mode, lr_mode;

  exc_seq #(.ADDR_W(AW), .VEC_BASE('0)) uut (
    .clk(clk), .rst(rst), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .irq(irq), .fiq(fiq),
    .next_pc(next_pc), .ret_req(ret_req), .lr_in(lr_in),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .pc_load(pc_load), .pc_out(pc_out), .mode(mode), .t_bit(t_bit),
    .i_bit(i_bit), .f_bit(f_bit), .lr_we(lr_we), .lr_mode(lr_mode),
    .lr_data(lr_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  bit    done   = 0;
  string cur    = "R1";

  // behavioural reference
  bit          mvalid = 0;
  int          m_mode;
  bit          m_t, m_i, m_f;
  bit [31:0]   e_pc;
  bit          e_pcl, e_lrwe;
  int          e_lrmode;
  bit [31:0]   e_lrdata;
  int          sv_mode[int];
  bit [2:0]    sv_tif[int];
  bit          sv_deep[int];

  function automatic bit slot_mode(int m);
    return (m == 'h11) || (m == 'h12) || (m == 'h13) || (m == 'h17) || (m == 'h1B);
  endfunction

  function automatic bit legal(int m);
    return slot_mode(m) || (m == 'h10) || (m == 'h1F);
  endfunction

  always @(posedge clk) begin
    int  tm;
    int  off;
    bit  hit;
    bit  deep;
    e_pcl  = 0;
    e_lrwe = 0;
    if (rst) begin
      mvalid = 1; m_mode = 'h13; m_t = 0; m_i = 1; m_f = 1;
      e_pc = 0; e_pcl = 1;
    end else begin
      hit = 1; deep = 0; tm = 0; off = 0;
      if (req_dabt)            begin tm = 'h17; off = 'h10; deep = 1; end
      else if (fiq && !m_f)    begin tm = 'h11; off = 'h1C; end
      else if (irq && !m_i)    begin tm = 'h12; off = 'h18; end
      else if (req_pabt)       begin tm = 'h17; off = 'h0C; end
      else if (req_undef)      begin tm = 'h1B; off = 'h04; end
      else if (req_swi)        begin tm = 'h13; off = 'h08; end
      else hit = 0;
      if (hit) begin
        sv_mode[tm] = m_mode; sv_tif[tm] = {m_t, m_i, m_f}; sv_deep[tm] = deep;
        if (tm == 'h11) m_f = 1;
        m_mode = tm; m_t = 0; m_i = 1;
        e_pc = off; e_pcl = 1; e_lrwe = 1; e_lrmode = tm; e_lrdata = next_pc;
      end else if (ret_req && slot_mode(m_mode)) begin
        e_pc = lr_in - (sv_deep[m_mode] ? 8 : 4); e_pcl = 1;
        {m_t, m_i, m_f} = sv_tif[m_mode];
        m_mode = sv_mode[m_mode];
      end else if (ctl_wr && m_mode != 'h10 && legal(int'(ctl_wdata[7:3]))) begin
        m_mode = int'(ctl_wdata[7:3]); {m_t, m_i, m_f} = ctl_wdata[2:0];
      end
    end
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mvalid && !done) begin
      chk(mode === 5'(m_mode), "mode", 32'(mode), 32'(m_mode));
      chk({t_bit, i_bit, f_bit} === {m_t, m_i, m_f}, "T/I/F",
          32'({t_bit, i_bit, f_bit}), 32'({m_t, m_i, m_f}));
      chk(pc_load === e_pcl, "pc_load", 32'(pc_load), 32'(e_pcl));
      chk(pc_out === e_pc, "pc_out", pc_out, e_pc);
      chk(lr_we === e_lrwe, "lr_we", 32'(lr_we), 32'(e_lrwe));
      if (e_lrwe) begin
        chk(lr_mode === 5'(e_lrmode), "lr_mode", 32'(lr_mode), 32'(e_lrmode));
        chk(lr_data === e_lrdata, "lr_data", lr_data, e_lrdata);
      end
    end
  end

  task automatic clr();
    {req_undef, req_swi, req_pabt, req_dabt, irq, fiq, ret_req, ctl_wr} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
  endtask

  task automatic wr(logic [4:0] m, logic [2:0] tif);
    ctl_wr = 1; ctl_wdata = {m, tif}; step();
  endtask

  task automatic ret(logic [31:0] lr);
    ret_req = 1; lr_in = lr; step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur = "R1"; step();
    // R10: privileged write to user, then user attempts are ignored
    cur = "R10"; wr(5'h10, 3'b011);
    wr(5'h13, 3'b000);
    wr(5'h1F, 3'b000);
    // R7: masked requests while I=F=1 in user mode
    cur = "R7"; irq = 1; step(); fiq = 1; step();
    // R9: return from user mode does nothing
    cur = "R9"; ret(32'h0000_5000);
    // R2 R5: software call from user mode
    cur = "R5"; next_pc = 32'h0000_0104; req_swi = 1; step();
    // R3 R8: return restores user, masks on
    cur = "R8"; ret(32'h0000_0104);
    // R9 again in user then reach system mode with interrupts open
    cur = "R2"; next_pc = 32'h0000_0200; req_swi = 1; step();
    cur = "R10"; wr(5'h0E, 3'b000);          // illegal mode, ignored
    wr(5'h1F, 3'b000);
    cur = "R9"; ret(32'h0000_7000);
    // R4: irq then nested fiq, F only raised by fiq
    cur = "R4"; next_pc = 32'h0000_0300; irq = 1; step();
    next_pc = 32'h0000_0020; fiq = 1; step();
    cur = "R3"; ret(32'h0000_0024); ret(32'h0000_0304);
    // R6: priority ladder from system mode with I=F=0
    cur = "R6"; next_pc = 32'h0000_0400;
    {req_dabt, fiq, irq, req_pabt, req_undef, req_swi} = '1; step();
    cur = "R8"; ret(32'h0000_0408);          // data abort: minus 8
    cur = "R6"; {fiq, irq, req_pabt, req_undef, req_swi} = '1; step();
    ret(32'h0000_0500);
    {irq, req_pabt, req_undef, req_swi} = '1; step();
    ret(32'h0000_0600);
    {req_pabt, req_undef, req_swi} = '1; step();
    cur = "R8"; ret(32'h0000_0700);          // prefetch abort: minus 4
    cur = "R6"; {req_undef, req_swi} = '1; step();
    ret(32'h0000_0800);
    // R11: collisions
    cur = "R11"; next_pc = 32'h0000_0900;
    req_swi = 1; ret_req = 1; ctl_wr = 1; ctl_wdata = {5'h10, 3'b000}; lr_in = 32'h1234; step();
    ret_req = 1; ctl_wr = 1; ctl_wdata = {5'h12, 3'b111}; lr_in = 32'h0000_0904; step();
    // R1: reset in the middle of activity
    cur = "R1"; rst = 1; irq = 1; step(); rst = 0; step();
    // mixed traffic with every slot already filled above
    cur = "R11";
    for (int n = 0; n < 600; n++) begin
      int legal_m[7] = '{'h10, 'h11, 'h12, 'h13, 'h17, 'h1B, 'h1F};
      next_pc   = $urandom;
      lr_in     = $urandom;
      req_dabt  = ($urandom % 12) == 0;
      req_pabt  = ($urandom % 12) == 0;
      req_undef = ($urandom % 12) == 0;
      req_swi   = ($urandom % 10) == 0;
      irq       = ($urandom % 6) == 0;
      fiq       = ($urandom % 8) == 0;
      ret_req   = ($urandom % 4) == 0;
      ctl_wr    = ($urandom % 6) == 0;
      ctl_wdata = {5'(legal_m[$urandom % 7]), 3'($urandom)};
      if (($urandom % 9) == 0) ctl_wdata[7:3] = 5'h05;
      step();
    end
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule